// File: doc/BRIEF.md
# Cluster-Aware Inter-Processor Doorbell

This block lets any core of a multi-cluster processor ring a doorbell on any other core, itself included. Cores are grouped into clusters. Each core owns two request write ports. The near-request port reaches only cores of the writer's own cluster and names just the core within that cluster. The far-request port reaches any core and names both the cluster and the core. A sender uses the near port when the target shares its cluster and the far port otherwise, although the far port works for every target.

Each core has a one-bit pending flag, seen as bit 0 of its status word. The flag is set by any valid request that names the core. It is cleared when software writes a one to bit 0 of the status word. The flag drives that core's fast-interrupt line directly. Requests that name a core or cluster that does not exist are dropped without effect.

Top module: `ipi_doorbell_fabric`

## Requirements
- R1: While reset is asserted, and after its release until the first request, every pending flag, every fast-interrupt line and every status word reads zero.
- R2: A near-request write from core s carrying core number k in bits 7:0 (k below the cores per cluster) sets the flag of core (s / cores_per_cluster) * cores_per_cluster + k at the next clock edge. Bits above 7 of a near request are ignored.
- R3: A far-request write carrying core number k in bits 7:0 and cluster number c in bits 15:8 sets the flag of core c * cores_per_cluster + k at the next clock edge, whatever the sender's cluster. Bits 31:16 are ignored.
- R4: A request whose core field is not below the cores per cluster, or a far request whose cluster field is not below the cluster count, changes no pending flag.
- R5: A core may name itself as the target through either port, and its own flag then becomes set.
- R6: A set flag stays set across any number of cycles until cleared. A status write with bit 0 equal to zero leaves it unchanged.
- R7: A status write with bit 0 equal to one clears that core's flag at the next clock edge and leaves every other core's flag unchanged.
- R8: When a valid request and a clearing status write reach the same core in the same cycle, the flag is set after the edge.
- R9: Each fast-interrupt line equals its core's pending flag. The status word holds the flag in bit 0 and zeros in bits 31:1.
- R10: Requests from several senders, and from both ports of one sender, in the same cycle all take effect together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| near_we | input | 8 | Per-core write strobe of the near-request port |
| near_wdata | input | 256 | Per-core near-request data, core s in bits 32s+31:32s |
| far_we | input | 8 | Per-core write strobe of the far-request port |
| far_wdata | input | 256 | Per-core far-request data, core s in bits 32s+31:32s |
| stat_we | input | 8 | Per-core write strobe of the status word |
| stat_wdata | input | 256 | Per-core status write data; bit 0 set means clear |
| stat_rdata | output | 256 | Per-core status word, flag in bit 0 |
| fiq | output | 8 | Per-core fast-interrupt line |

## Verification
Every flag is a single register that feeds its line and its status word with no logic in between. A wrong target decode therefore shows on the fast-interrupt vector one edge after the request, as a line on the wrong core or a line missing on the right one. A flag that drops by itself, or survives a clear, shows on the next sample after the edge where it should have held or fallen. Because a stuck or lost state stays visible until the next clear, each check compares the whole eight-line vector together with every status word, and the set-against-clear race is driven in a single cycle.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;

  // Which request port a decoder instance serves.
  typedef enum logic [0:0] {
    REQ_NEAR = 1'b0,
    REQ_FAR  = 1'b1
  } req_kind_e;

  // Cluster that a given flat core index belongs to.
  function automatic int cluster_of(input int core_idx, input int cores_per_cl);
    return core_idx / cores_per_cl;
  endfunction

endpackage

// File: rtl/ipi_rst_sync.sv
`timescale 1ns/1ps
module ipi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ipi_req_decode.sv
`timescale 1ns/1ps
module ipi_req_decode
  import ipi_pkg::*;
#(
  parameter int        N_CLUSTERS   = 2,
  parameter int        CORES_PER_CL = 4,
  parameter int        CORE_W       = 8,
  parameter int        CLUSTER_W    = 8,
  parameter int        DATA_W       = 32,
  parameter int        SRC_ID       = 0,
  parameter req_kind_e KIND         = REQ_NEAR
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we,
  input  logic [DATA_W-1:0]                    wdata,
  output logic [N_CLUSTERS*CORES_PER_CL-1:0]   hit
);

  localparam int N_CORES = N_CLUSTERS * CORES_PER_CL;
  localparam int SRC_CL  = cluster_of(SRC_ID, CORES_PER_CL);

  logic [CORE_W-1:0]    core_f;
  logic [CLUSTER_W-1:0] cl_sel;
  logic                 core_ok;
  logic                 cl_ok;
  logic                 req_ok;
  int                   tgt_idx;

  assign core_f = wdata[CORE_W-1:0];

  generate
    if (KIND == REQ_NEAR) begin : g_near
      assign cl_sel = CLUSTER_W'(SRC_CL);
      logic unused_near;
      assign unused_near = ^{wdata[DATA_W-1:CORE_W]};
    end else begin : g_far
      assign cl_sel = wdata[CORE_W +: CLUSTER_W];
      if (DATA_W > CORE_W + CLUSTER_W) begin : g_spare
        logic unused_far;
        assign unused_far = ^{wdata[DATA_W-1:CORE_W+CLUSTER_W]};
      end
    end
  endgenerate

  always_comb begin
    core_ok = (core_f < CORE_W'(CORES_PER_CL));
    cl_ok   = (cl_sel < CLUSTER_W'(N_CLUSTERS));
    req_ok  = we && core_ok && cl_ok;
    tgt_idx = int'(cl_sel) * CORES_PER_CL + int'(core_f);
    for (int t = 0; t < N_CORES; t++) begin
      hit[t] = req_ok && (tgt_idx == t);
    end
  end

  // R4: a core field out of range never reaches a pending flag
  a_r4_core_range: assert property (@(posedge clk) disable iff (!rst_n)
    (core_f >= CORE_W'(CORES_PER_CL)) |-> (hit == '0));

  // R4: a cluster field out of range never reaches a pending flag
  a_r4_cluster_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata[CORE_W +: CLUSTER_W] >= CLUSTER_W'(N_CLUSTERS) && KIND == REQ_FAR)
      |-> (hit == '0));

  // R2: one request names at most one target, and only when strobed
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit) && (we || hit == '0));

endmodule

// File: rtl/ipi_pend_cell.sv
`timescale 1ns/1ps
module ipi_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_we,
  input  logic clr_bit,
  output logic pend
);

  logic pend_q;
  logic pend_d;
  logic pend_en;
  logic clr_req;

  always_comb begin
    clr_req = clr_we && clr_bit;
    pend_en = set_req || clr_req;
    pend_d  = set_req;   // set wins; otherwise an enabled update is a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R8: a request in the same cycle as a clear leaves the flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> pend);

  // R7: a clear without a request drops the flag
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bit && !set_req) |=> !pend);

  // R6: with no request and no clearing write, the flag holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_req && !(clr_we && clr_bit)) |=> $stable(pend));

endmodule

// File: rtl/ipi_doorbell_fabric.sv
`timescale 1ns/1ps
module ipi_doorbell_fabric
  import ipi_pkg::*;
#(
  parameter int N_CLUSTERS   = 2,
  parameter int CORES_PER_CL = 4,
  parameter int CORE_W       = 8,
  parameter int CLUSTER_W    = 8,
  parameter int DATA_W       = 32
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [N_CLUSTERS*CORES_PER_CL-1:0]          near_we,
  input  logic [N_CLUSTERS*CORES_PER_CL*DATA_W-1:0]   near_wdata,
  input  logic [N_CLUSTERS*CORES_PER_CL-1:0]          far_we,
  input  logic [N_CLUSTERS*CORES_PER_CL*DATA_W-1:0]   far_wdata,
  input  logic [N_CLUSTERS*CORES_PER_CL-1:0]          stat_we,
  input  logic [N_CLUSTERS*CORES_PER_CL*DATA_W-1:0]   stat_wdata,
  output logic [N_CLUSTERS*CORES_PER_CL*DATA_W-1:0]   stat_rdata,
  output logic [N_CLUSTERS*CORES_PER_CL-1:0]          fiq
);

  localparam int N_CORES = N_CLUSTERS * CORES_PER_CL;

  logic               rst_n_s;
  logic [N_CORES-1:0] near_hit [N_CORES];
  logic [N_CORES-1:0] far_hit  [N_CORES];
  logic [N_CORES-1:0] set_vec;
  logic [N_CORES-1:0] pend_vec;

  ipi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  generate
    for (genvar s = 0; s < N_CORES; s++) begin : g_src
      ipi_req_decode #(
        .N_CLUSTERS(N_CLUSTERS), .CORES_PER_CL(CORES_PER_CL),
        .CORE_W(CORE_W), .CLUSTER_W(CLUSTER_W), .DATA_W(DATA_W),
        .SRC_ID(s), .KIND(REQ_NEAR)
      ) u_near (
        .clk   (clk),
        .rst_n (rst_n_s),
        .we    (near_we[s]),
        .wdata (near_wdata[s*DATA_W +: DATA_W]),
        .hit   (near_hit[s])
      );

      ipi_req_decode #(
        .N_CLUSTERS(N_CLUSTERS), .CORES_PER_CL(CORES_PER_CL),
        .CORE_W(CORE_W), .CLUSTER_W(CLUSTER_W), .DATA_W(DATA_W),
        .SRC_ID(s), .KIND(REQ_FAR)
      ) u_far (
        .clk   (clk),
        .rst_n (rst_n_s),
        .we    (far_we[s]),
        .wdata (far_wdata[s*DATA_W +: DATA_W]),
        .hit   (far_hit[s])
      );
    end
  endgenerate

  // Gather every sender's decoded targets into one set vector.
  always_comb begin
    set_vec = '0;
    for (int s = 0; s < N_CORES; s++) begin
      set_vec = set_vec | near_hit[s] | far_hit[s];
    end
  end

  generate
    for (genvar t = 0; t < N_CORES; t++) begin : g_tgt
      ipi_pend_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n_s),
        .set_req (set_vec[t]),
        .clr_we  (stat_we[t]),
        .clr_bit (stat_wdata[t*DATA_W]),
        .pend    (pend_vec[t])
      );

      assign stat_rdata[t*DATA_W +: DATA_W] = {{(DATA_W-1){1'b0}}, pend_vec[t]};
      assign fiq[t] = pend_vec[t];

      logic unused_stat;
      assign unused_stat = ^{stat_wdata[t*DATA_W+1 +: DATA_W-1]};

      // R9: a line only rises one edge after a request reached that core
      a_r9_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n_s)
        $rose(fiq[t]) |-> $past(set_vec[t]));
    end
  endgenerate

  // R1: while the internal reset is held, no line is raised
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n_s |-> (fiq == '0));

endmodule

// File: tb/sim_ipi_doorbell_fabric.sv
`timescale 1ns/1ps
module sim_ipi_doorbell_fabric;

  localparam int NC = 8;
  localparam int DW = 32;
  localparam int NV = 14;

  logic              clk;
  logic              rst_n;
  logic [NC-1:0]     near_we, far_we, stat_we;
  logic [NC*DW-1:0]  near_wdata, far_wdata, stat_wdata;
  logic [NC*DW-1:0]  stat_rdata;
  logic [NC-1:0]     fiq;

  int n_chk;
  int n_err;
  bit done;

  ipi_doorbell_fabric u0 (
    .clk(clk), .rst_n(rst_n),
    .near_we(near_we), .near_wdata(near_wdata),
    .far_we(far_we), .far_wdata(far_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata),
    .stat_rdata(stat_rdata), .fiq(fiq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // {kind(4): 0 near / 1 far, src(4), data(32), expected lines(8)}
  localparam logic [47:0] VEC [NV] = '{
    {4'd0, 4'd0, 32'h0000_0002, 8'h04},  // R2 near within cluster 0
    {4'd0, 4'd5, 32'h0000_0001, 8'h20},  // R2 near within cluster 1
    {4'd0, 4'd6, 32'h0000_0003, 8'h80},  // R2 near top core
    {4'd1, 4'd1, 32'h0000_0103, 8'h80},  // R3 far into cluster 1
    {4'd1, 4'd6, 32'h0000_0000, 8'h01},  // R3 far into cluster 0
    {4'd1, 4'd4, 32'h0000_0102, 8'h40},  // R3 far to own cluster
    {4'd0, 4'd3, 32'h0000_0003, 8'h08},  // R5 self through near
    {4'd1, 4'd2, 32'h0000_0002, 8'h04},  // R5 self through far
    {4'd0, 4'd0, 32'h0000_0004, 8'h00},  // R4 near core out of range
    {4'd1, 4'd0, 32'h0000_0200, 8'h00},  // R4 far cluster out of range
    {4'd1, 4'd0, 32'h0000_0005, 8'h00},  // R4 far core out of range
    {4'd0, 4'd4, 32'h0000_0100, 8'h10},  // R2 near ignores bits above 7
    {4'd1, 4'd7, 32'hFFFF_0001, 8'h02},  // R3 far ignores bits 31:16
    {4'd0, 4'd1, 32'h0000_00FF, 8'h00}   // R4 near core field all ones
  };

  task automatic idle_inputs();
    near_we = '0; far_we = '0; stat_we = '0;
    near_wdata = '0; far_wdata = '0; stat_wdata = '0;
  endtask

  task automatic check(input string tag, input logic [NC-1:0] exp);
    logic bad;
    bad = (fiq !== exp);
    for (int i = 0; i < NC; i++) begin
      if (stat_rdata[i*DW +: DW] !== {31'b0, exp[i]}) bad = 1'b1;
    end
    n_chk++;
    if (bad) begin
      n_err++;
      $display("FAIL %s: fiq=%h status0=%h expected fiq=%h", tag, fiq,
               stat_rdata[DW-1:0], exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic clear_all();
    idle_inputs();
    stat_we = '1;
    for (int i = 0; i < NC; i++) stat_wdata[i*DW] = 1'b1;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic send(input logic kind, input int src, input logic [31:0] data);
    idle_inputs();
    if (kind) begin
      far_we[src] = 1'b1;
      far_wdata[src*DW +: DW] = data;
    end else begin
      near_we[src] = 1'b1;
      near_wdata[src*DW +: DW] = data;
    end
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    done  = 0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset release", 8'h00);

    // Vector table: each entry alone, from a cleared state.
    for (int v = 0; v < NV; v++) begin
      clear_all();
      send(VEC[v][47:44] != 4'd0, int'(VEC[v][43:40]), VEC[v][39:8]);
      check($sformatf("R2/R3/R4/R5/R9 vector %0d", v), VEC[v][7:0]);
    end

    // R6: flag holds over idle cycles and over a status write of zero
    clear_all();
    send(1'b0, 0, 32'h2);
    repeat (5) @(negedge clk);
    check("R6 hold over idle", 8'h04);
    stat_we[2] = 1'b1;
    stat_wdata[2*DW +: DW] = 32'hFFFF_FFFE;
    @(negedge clk);
    idle_inputs();
    check("R6 write of zero keeps flag", 8'h04);
    send(1'b1, 3, 32'h0002);
    check("R6 repeat request keeps flag", 8'h04);

    // R7: clear one core, neighbour untouched
    send(1'b1, 0, 32'h0101);
    check("R7 setup two flags", 8'h24);
    stat_we[2] = 1'b1;
    stat_wdata[2*DW] = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R7 clear only core 2", 8'h20);

    // R8: request and clear to core 5 in the same cycle
    near_we[4] = 1'b1;
    near_wdata[4*DW +: DW] = 32'h1;
    stat_we[5] = 1'b1;
    stat_wdata[5*DW] = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R8 set wins over clear", 8'h20);
    stat_we[5] = 1'b1;
    stat_wdata[5*DW] = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R7 later clear alone", 8'h00);

    // R10: several senders and both ports of one sender together
    near_we[0] = 1'b1;  near_wdata[0*DW +: DW] = 32'h1;
    far_we[0]  = 1'b1;  far_wdata[0*DW +: DW]  = 32'h0100;
    far_we[5]  = 1'b1;  far_wdata[5*DW +: DW]  = 32'h0103;
    near_we[6] = 1'b1;  near_wdata[6*DW +: DW] = 32'h7;   // out of range
    @(negedge clk);
    idle_inputs();
    check("R10 concurrent requests", 8'h92);

    // R1: asynchronous reset in the middle of activity
    rst_n = 1'b0;
    #1;
    check("R1 reset clears pending flags", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 quiet after second reset", 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule